// File: doc/BRIEF.md
# Redirection-Entry Interrupt Dispatcher

This block turns interrupt requests on a set of numbered pins into message-signalled interrupts. Each pin has a redirection entry held outside the block, in a table that the block reads as a flat bus. The block keeps one pending bit per pin, the interrupt request register (IRR). A request event names a pin and a level, and updates that bit according to the pin's trigger mode and mask. Pending pins are then scanned, and each eligible one is turned into a 32-bit address and a 32-bit data word on a valid/ready output.

For level-triggered entries the block asks the table to set the entry's remote-IRR bit, through a one-cycle `set_rirr` strobe, when it dispatches them. While that bit stays set, further assertions on the same pin are coalesced and send no message. Clearing remote IRR belongs to the table owner. After clearing it, the owner pulses `tbl_write`, and the block scans again.

Each table entry is `ENTRY_W` = 31 bits wide. Entry *i* sits at `tbl_entries[i*31 +: 31]` and has these fields:

| Bits | Field |
|------|-------|
| [7:0] | vector |
| [10:8] | delivery mode |
| [11] | destination mode |
| [12] | remote IRR |
| [13] | trigger mode (1 = level, 0 = edge) |
| [14] | mask |
| [30:15] | destination |

Top module: `irq_redirect_dispatch`

## Requirements
- R1: A request on pin 0 is handled as a request on pin 2. A request whose pin index is `NUM_PINS` or above changes no IRR bit and sends no message.
- R2: For a level entry (bit 13 = 1), an asserted request sets the pin's IRR bit, and a deasserted request clears it. A new scan starts only if the entry's remote IRR (bit 12) is clear.
- R3: For an edge entry (bit 13 = 0), an asserted request with mask (bit 14) clear sets IRR and starts a scan. With mask set, the request is discarded: IRR stays as it was, and no message follows, even after a later unmask.
- R4: A scan dispatches pending pins from the lowest index upward. Masked pins are skipped, and their IRR bit stays set.
- R5: Dispatching an edge entry clears its IRR bit. Dispatching a level entry keeps its IRR bit and raises `set_rirr` for that pin only, during the cycle in which the message is loaded.
- R6: A level entry whose remote IRR is already set is not dispatched and produces no message.
- R7: `msg_addr` = 0xFEE00000 OR (destination, bits [30:15] of the entry, shifted left by 12) OR (destination mode, bit 11, shifted left by 2).
- R8: `msg_data` holds the vector in bits [7:0], the delivery mode in bits [10:8] and the trigger mode in bit 15; all other bits are zero.
- R9: A `tbl_write` pulse starts a new scan over all pins.
- R10: At most one message is outstanding. While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request event strobe |
| req_pin | input | $clog2(NUM_PINS) | Pin index of the request |
| req_level | input | 1 | Level carried by the request (1 = asserted) |
| tbl_entries | input | NUM_PINS*31 | Flat view of all redirection entries |
| tbl_write | input | 1 | Pulse: some entry was rewritten |
| set_rirr | output | NUM_PINS | One-hot strobe asking the table to set remote IRR |
| pending_irr | output | NUM_PINS | Current IRR bits |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
Assertions check, on every cycle:
- the output hold under back-pressure;
- that `set_rirr` is one-hot and is always followed by a level-trigger message;
- that a level entry already holding remote IRR never gets a strobe;
- the fixed zero and base bits of both message words;
- that the dispatch winner is the lowest eligible pin;
- the IRR effects of level deassertion, dispatch and masked-edge drops.

Only the bench scenarios show the rest:
- the full field mapping for every pin;
- the pin-0 redirection;
- out-of-range pins being ignored;
- the ordering of several pins released by one table write;
- coalescing until the table clears remote IRR.

// File: rtl/irqrd_pkg.sv
package irqrd_pkg;

  localparam int ENTRY_W = 31;
  localparam logic [31:0] MSG_BASE = 32'hFEE0_0000;
  localparam int DEST_SHIFT = 12;
  localparam int DMODE_SHIFT = 2;

  typedef struct packed {
    logic [15:0] dest;
    logic        masked;
    logic        level;
    logic        rirr;
    logic        dest_mode;
    logic [2:0]  deliv;
    logic [7:0]  vector;
  } rte_t;

  function automatic logic [31:0] form_addr(rte_t e);
    return MSG_BASE
         | ({16'h0, e.dest} << DEST_SHIFT)
         | ({31'h0, e.dest_mode} << DMODE_SHIFT);
  endfunction

  function automatic logic [31:0] form_data(rte_t e);
    return {16'h0, e.level, 4'h0, e.deliv, e.vector};
  endfunction

endpackage

// File: rtl/irqrd_pending.sv
module irqrd_pending #(
  parameter int NUM_PINS   = 24,
  parameter int LEGACY_SRC = 0,
  parameter int LEGACY_DST = 2,
  localparam int PW = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [PW-1:0]       req_pin,
  input  logic                req_level,
  input  logic [NUM_PINS-1:0] lvl_vec,
  input  logic [NUM_PINS-1:0] mask_vec,
  input  logic [NUM_PINS-1:0] rirr_vec,
  input  logic [NUM_PINS-1:0] dispatch_clr,
  output logic [NUM_PINS-1:0] irr_q,
  output logic                scan_kick
);

  logic [PW-1:0]       pin_eff;
  logic                in_range;
  logic [NUM_PINS-1:0] req_oh;
  logic [NUM_PINS-1:0] set_vec;
  logic [NUM_PINS-1:0] lvl_clr_vec;
  logic [NUM_PINS-1:0] drop_vec;
  logic                is_lvl, is_masked, has_rirr;

  assign pin_eff  = (req_pin == PW'(LEGACY_SRC)) ? PW'(LEGACY_DST) : req_pin;
  assign in_range = ({1'b0, pin_eff} < (PW+1)'(NUM_PINS));
  assign req_oh   = (req_valid && in_range) ? (NUM_PINS'(1) << pin_eff) : '0;

  assign is_lvl    = |(req_oh & lvl_vec);
  assign is_masked = |(req_oh & mask_vec);
  assign has_rirr  = |(req_oh & rirr_vec);

  always_comb begin
    set_vec     = '0;
    lvl_clr_vec = '0;
    drop_vec    = '0;
    scan_kick   = 1'b0;
    if (req_oh != '0) begin
      if (is_lvl) begin
        if (req_level) begin
          set_vec   = req_oh;
          scan_kick = !has_rirr;
        end else begin
          lvl_clr_vec = req_oh;
        end
      end else if (req_level) begin
        if (is_masked) begin
          drop_vec = req_oh;
        end else begin
          set_vec   = req_oh;
          scan_kick = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irr_q <= '0;
    else        irr_q <= (irr_q & ~dispatch_clr & ~lvl_clr_vec) | set_vec;
  end

  assert_level_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_clr_vec != '0) |=> ((irr_q & $past(lvl_clr_vec)) == '0));

  assert_masked_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_vec != '0) |=> (((irr_q ^ $past(irr_q)) & $past(drop_vec)) == '0));

endmodule

// File: rtl/irqrd_pick.sv
module irqrd_pick #(
  parameter int NUM_PINS = 24
) (
  input  logic [NUM_PINS-1:0] elig,
  output logic [NUM_PINS-1:0] grant,
  output logic                any
);

  function automatic logic [NUM_PINS-1:0] lowest_set(logic [NUM_PINS-1:0] v);
    return v & (~v + NUM_PINS'(1));
  endfunction

  assign grant = lowest_set(elig);
  assign any   = |elig;

  always_comb begin
    assert_grant_lowest_R4: assert (((grant - NUM_PINS'(1)) & elig & {NUM_PINS{grant != '0}}) == '0);
    assert_grant_subset_R4: assert ($onehot0(grant) && ((grant & ~elig) == '0));
  end

endmodule

// File: rtl/irq_redirect_dispatch.sv
module irq_redirect_dispatch #(
  parameter int NUM_PINS   = 24,
  parameter int LEGACY_SRC = 0,
  parameter int LEGACY_DST = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 req_valid,
  input  logic [$clog2(NUM_PINS)-1:0]          req_pin,
  input  logic                                 req_level,
  input  logic [NUM_PINS*irqrd_pkg::ENTRY_W-1:0] tbl_entries,
  input  logic                                 tbl_write,
  output logic [NUM_PINS-1:0]                  set_rirr,
  output logic [NUM_PINS-1:0]                  pending_irr,
  output logic                                 msg_valid,
  input  logic                                 msg_ready,
  output logic [31:0]                          msg_addr,
  output logic [31:0]                          msg_data
);
  import irqrd_pkg::*;

  rte_t                rte [NUM_PINS];
  logic [NUM_PINS-1:0] lvl_vec, mask_vec, rirr_vec;
  logic [NUM_PINS-1:0] irr_q, scan_set_q, elig, grant, dispatch_clr;
  logic                scan_kick, slot_free, load;
  logic [ENTRY_W-1:0]  sel_raw;
  rte_t                sel;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_unpack
    assign rte[i]      = rte_t'(tbl_entries[i*ENTRY_W +: ENTRY_W]);
    assign lvl_vec[i]  = rte[i].level;
    assign mask_vec[i] = rte[i].masked;
    assign rirr_vec[i] = rte[i].rirr;
  end

  irqrd_pending #(
    .NUM_PINS(NUM_PINS), .LEGACY_SRC(LEGACY_SRC), .LEGACY_DST(LEGACY_DST)
  ) u_pending (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_pin(req_pin), .req_level(req_level),
    .lvl_vec(lvl_vec), .mask_vec(mask_vec), .rirr_vec(rirr_vec),
    .dispatch_clr(dispatch_clr), .irr_q(irr_q), .scan_kick(scan_kick)
  );

  assign slot_free = !msg_valid || msg_ready;
  assign elig = slot_free ? (scan_set_q & irr_q & ~mask_vec & ~(lvl_vec & rirr_vec)) : '0;

  irqrd_pick #(.NUM_PINS(NUM_PINS)) u_pick (
    .elig(elig), .grant(grant), .any(load)
  );

  assign set_rirr     = grant & lvl_vec;
  assign dispatch_clr = grant & ~lvl_vec;
  assign pending_irr  = irr_q;

  always_comb begin
    sel_raw = '0;
    for (int i = 0; i < NUM_PINS; i++)
      if (grant[i]) sel_raw = sel_raw | rte[i];
  end
  assign sel = rte_t'(sel_raw);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_set_q <= '0;
    end else if (scan_kick || tbl_write) begin
      scan_set_q <= '1;
    end else if (slot_free) begin
      scan_set_q <= load ? (scan_set_q & ~grant) : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (load) begin
      msg_valid <= 1'b1;
      msg_addr  <= form_addr(sel);
      msg_data  <= form_data(sel);
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  assert_msg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  assert_rirr_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_rirr));

  assert_rirr_with_msg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_rirr != '0) |=> (msg_valid && msg_data[15]));

  assert_level_keeps_irr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_rirr != '0 && !req_valid) |=> ((pending_irr & $past(set_rirr)) == $past(set_rirr)));

  assert_edge_clears_irr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dispatch_clr != '0 && !req_valid) |=> ((pending_irr & $past(dispatch_clr)) == '0));

  assert_no_resend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_rirr & rirr_vec) == '0);

  assert_addr_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_addr[31:28] == 4'hF && msg_addr[11:3] == '0 && msg_addr[1:0] == '0));

  assert_data_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_data[31:16] == '0 && msg_data[14:11] == '0));

endmodule

// File: tb/irq_redirect_dispatch_bench.sv
module irq_redirect_dispatch_bench;
  localparam int N  = 24;
  localparam int EW = 31;
  localparam int PW = $clog2(N);

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic [PW-1:0] req_pin = '0;
  logic req_level = 0;
  logic [N*EW-1:0] tbl_entries;
  logic tbl_write = 0;
  logic [N-1:0] set_rirr, pending_irr;
  logic msg_valid, msg_ready = 1;
  logic [31:0] msg_addr, msg_data;

  logic [EW-1:0] tbl [N];
  logic [63:0] msg_q [$];
  int checks = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  irq_redirect_dispatch #(.NUM_PINS(N)) u_irq_redirect_dispatch (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pin(req_pin),
    .req_level(req_level), .tbl_entries(tbl_entries), .tbl_write(tbl_write),
    .set_rirr(set_rirr), .pending_irr(pending_irr), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  always_comb
    for (int i = 0; i < N; i++) tbl_entries[i*EW +: EW] = tbl[i];

  // external table: remote IRR set on strobe; monitor of accepted messages
  always @(posedge clk) begin
    cycles <= cycles + 1;
    for (int i = 0; i < N; i++)
      if (set_rirr[i]) tbl[i][12] <= 1'b1;
    if (msg_valid && msg_ready) msg_q.push_back({msg_addr, msg_data});
    if (cycles == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic logic [EW-1:0] mk(input logic [7:0] vec, input logic [2:0] dl,
      input logic dm, input logic rr, input logic lv, input logic mk_, input logic [15:0] dst);
    return {dst, mk_, lv, rr, dm, dl, vec};
  endfunction

  function automatic logic [31:0] exp_addr(input logic [EW-1:0] e);
    return 32'hFEE0_0000 | (32'(e[30:15]) * 32'd4096) | (32'(e[11]) * 32'd4);
  endfunction

  function automatic logic [31:0] exp_data(input logic [EW-1:0] e);
    return 32'(e[7:0]) + 32'(e[10:8]) * 32'd256 + 32'(e[13]) * 32'd32768;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic req(input int pin, input logic lvl);
    @(negedge clk);
    req_valid = 1; req_pin = PW'(pin); req_level = lvl;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic twrite();
    @(negedge clk);
    tbl_write = 1;
    @(negedge clk);
    tbl_write = 0;
  endtask

  task automatic expect_msg(input logic [EW-1:0] e, input string tag);
    logic [63:0] got;
    for (int k = 0; k < 40 && msg_q.size() == 0; k++) @(negedge clk);
    if (msg_q.size() == 0) begin
      chk(0, tag, 64'h0, {exp_addr(e), exp_data(e)});
    end else begin
      got = msg_q.pop_front();
      chk(got == {exp_addr(e), exp_data(e)}, tag, got, {exp_addr(e), exp_data(e)});
    end
  endtask

  task automatic expect_none(input string tag);
    for (int k = 0; k < 12; k++) @(negedge clk);
    chk(msg_q.size() == 0 && !msg_valid, tag, 64'(msg_q.size()), 64'h0);
    msg_q.delete();
  endtask

  initial begin
    logic [N-1:0] snap;
    logic [31:0] a0, d0;
    for (int i = 0; i < N; i++) tbl[i] = mk(8'h00, 3'd0, 0, 0, 0, 1, 16'h0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!msg_valid && pending_irr == '0 && set_rirr == '0, "reset", {31'h0, msg_valid, 8'h0, pending_irr}, 64'h0);

    // R7 R8 R3 R5: edge sweep over every pin
    for (int p = 1; p < N; p++) begin
      tbl[p] = mk(8'(8'h30 + p), 3'(p % 8), p[0], 0, 0, 0, {8'(p), ~8'(p)});
      req(p, 1);
      expect_msg(tbl[p], $sformatf("R7 R8 R3 edge pin %0d", p));
      chk(pending_irr[p] == 0, "R5 edge irr cleared", 64'(pending_irr[p]), 64'h0);
    end

    // R1: pin 0 is redirected to pin 2
    tbl[2] = mk(8'hA2, 3'd5, 1, 0, 0, 0, 16'hBEEF);
    req(0, 1);
    expect_msg(tbl[2], "R1 pin0 to pin2");

    // R1: pins at or beyond NUM_PINS are ignored
    for (int p = N; p < (1 << PW); p++) begin
      snap = pending_irr;
      req(p, 1);
      expect_none($sformatf("R1 out-of-range pin %0d msg", p));
      chk(pending_irr == snap, "R1 out-of-range irr", 64'(pending_irr), 64'(snap));
    end

    // R3: masked edge request discarded, stays lost after unmask
    tbl[6] = mk(8'h66, 3'd1, 0, 0, 0, 1, 16'h0006);
    req(6, 1);
    expect_none("R3 masked edge no msg");
    chk(pending_irr[6] == 0, "R3 masked edge irr", 64'(pending_irr[6]), 64'h0);
    tbl[6][14] = 0;
    twrite();
    expect_none("R3 dropped edge after unmask");

    // R2 R5 R6: level pin, coalescing and deassert
    tbl[4] = mk(8'h44, 3'd0, 1, 0, 1, 0, 16'h1234);
    req(4, 1);
    expect_msg(tbl[4], "R2 level dispatch");
    chk(pending_irr[4] == 1 && tbl[4][12] == 1, "R5 level keeps irr sets rirr",
        {62'h0, pending_irr[4], tbl[4][12]}, 64'h3);
    req(4, 1);
    expect_none("R6 coalesced while rirr set");
    req(4, 0);
    @(negedge clk);
    chk(pending_irr[4] == 0, "R2 level deassert clears irr", 64'(pending_irr[4]), 64'h0);

    // R2 R9: level assert with rirr preset, released by table write
    tbl[9] = mk(8'h99, 3'd2, 0, 1, 1, 0, 16'h0909);
    req(9, 1);
    expect_none("R2 no scan when rirr set");
    chk(pending_irr[9] == 1, "R2 level irr set", 64'(pending_irr[9]), 64'h1);
    tbl[9][12] = 0;
    twrite();
    expect_msg(mk(8'h99, 3'd2, 0, 0, 1, 0, 16'h0909), "R9 rescan after write");

    // R4 R10: masked level pins released together, ascending order, stall
    msg_ready = 0;
    tbl[20] = mk(8'hD0, 3'd7, 1, 0, 1, 1, 16'h2020);
    tbl[7]  = mk(8'h77, 3'd3, 0, 0, 1, 1, 16'h0707);
    tbl[12] = mk(8'hC0, 3'd4, 1, 0, 1, 1, 16'h1212);
    req(20, 1); req(7, 1); req(12, 1);
    expect_none("R4 masked level skipped");
    chk(pending_irr[7] && pending_irr[12] && pending_irr[20], "R4 masked irr kept",
        64'(pending_irr), 64'h101080);
    tbl[7][14] = 0; tbl[12][14] = 0; tbl[20][14] = 0;
    twrite();
    repeat (3) @(negedge clk);
    a0 = msg_addr; d0 = msg_data;
    repeat (4) @(negedge clk);
    chk(msg_valid && msg_addr == a0 && msg_data == d0, "R10 held under stall",
        {msg_addr, msg_data}, {a0, d0});
    chk({a0, d0} == {exp_addr(tbl[7]), exp_data(tbl[7])}, "R4 first is pin 7",
        {a0, d0}, {exp_addr(tbl[7]), exp_data(tbl[7])});
    msg_ready = 1;
    expect_msg(mk(8'h77, 3'd3, 0, 0, 1, 0, 16'h0707), "R4 order pin 7");
    expect_msg(mk(8'hC0, 3'd4, 1, 0, 1, 0, 16'h1212), "R4 order pin 12");
    expect_msg(mk(8'hD0, 3'd7, 1, 0, 1, 0, 16'h2020), "R4 order pin 20");

    // R10 R5: two edge requests on one pin give two messages
    tbl[15] = mk(8'h5F, 3'd6, 1, 0, 0, 0, 16'hFFFF);
    req(15, 1);
    req(15, 1);
    expect_msg(tbl[15], "R10 edge repeat 1");
    expect_msg(tbl[15], "R10 edge repeat 2");
    expect_none("R10 no extra message");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule